// File: doc/BRIEF.md
# Precise Exception Control for a Six-Stage In-Order Pipeline

This block holds the control state of a six-stage in-order pipeline: address, fetch, decode, execute, memory and writeback. Each stage slot carries a valid bit, a kill bit, the instruction address and a three-bit cause tag. A fault found early does not act when it is found. It is written into the cause tag of its instruction and moves with it. An instruction translation miss is marked as the instruction leaves fetch. A system call is marked as it leaves decode. The exception is taken only when the tagged instruction sits in execute. A data translation miss is reported directly for the instruction in the memory stage. Because that instruction is older than the one in execute, it wins when both fault in the same cycle.

Flushes do not empty the slots. The instructions stay in their slots with the kill bit set, keep moving, and never retire. A branch mispredict resolved in execute uses the same kill path and spares the branch itself. A global stall freezes every slot and makes the fault and mispredict inputs of that cycle irrelevant. A taken exception captures the faulting address and its cause. It also raises a one-cycle redirect toward a fixed handler vector.

Top module: `pxc_pipe_ctrl`

## Requirements
- R1: While reset is asserted and directly after its release, `redirect_o`, `retire_valid_o`, `epc_o` and `cause_o` are all zero.
- R2: An instruction entering with `in_valid_i` high moves one stage per unstalled cycle. If no fault or flush touches it, it retires in program order: `retire_valid_o` is high with `retire_pc_o` equal to its address, on the cycle it leaves writeback.
- R3: While `stall_i` is high, no slot changes and `retire_valid_o` is low. The fault and mispredict inputs of that cycle are ignored: they cause no redirect and leave `epc_o` and `cause_o` unchanged.
- R4: `itlb_miss_i` during an unstalled cycle tags the live instruction leaving fetch. When that instruction is in execute on an unstalled cycle, the exception is taken with `epc_o` set to its address and `cause_o` = 1. Older instructions still retire.
- R5: `syscall_i` during an unstalled cycle tags the live instruction leaving decode with `cause_o` code 3. It does not replace an instruction translation miss already tagged, which keeps code 1.
- R6: `dtlb_miss_i` during an unstalled cycle, with a live instruction in memory, takes an exception with `epc_o` = that instruction's address and `cause_o` = 2. That instruction and all younger ones never retire.
- R7: If the memory stage has a data miss in the same cycle as a tagged instruction in execute, the memory-stage exception is the one taken (cause 2, memory address). The tagged younger instruction is killed and raises nothing later.
- R8: A taken exception kills the faulting instruction, every younger instruction in the pipeline and the instruction entering on that same edge. Faults reported later for killed instructions are ignored.
- R9: `mispredict_i` on an unstalled cycle, with a live untagged instruction in execute, kills the instructions in address, fetch and decode and the one entering on that edge. The branch itself retires normally.
- R10: Each taken exception produces exactly one cycle of `redirect_o`, in the cycle after it is taken, even when that cycle is stalled. During that cycle `redirect_pc_o` equals `HANDLER_VEC` and `cause_o` is 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Global freeze of all stages |
| in_valid_i | input | 1 | An instruction enters the address stage |
| in_pc_i | input | PC_W | Address of the entering instruction |
| itlb_miss_i | input | 1 | Translation miss for the instruction in fetch |
| syscall_i | input | 1 | Instruction in decode is a system call |
| mispredict_i | input | 1 | Branch in execute was mispredicted |
| dtlb_miss_i | input | 1 | Translation miss for the instruction in memory |
| retire_valid_o | output | 1 | A live instruction leaves writeback this cycle |
| retire_pc_o | output | PC_W | Address of the writeback instruction |
| redirect_o | output | 1 | One-cycle exception redirect |
| redirect_pc_o | output | PC_W | Handler vector while redirecting, else zero |
| epc_o | output | PC_W | Address of the last excepting instruction |
| cause_o | output | 3 | Cause code of the last exception |

## Verification
The bench sweeps every fault kind over every position of an eight-instruction run, with several stall and bubble patterns. It also covers a data miss that lands in the same cycle as a younger tagged fault, and mispredicts whose kill window covers instructions carrying faults. Each case has its own expected effect. A design that took the execute fault first would report cause 1 at the younger address. Tagging a fault onto a killed instruction would raise a second, spurious redirect. Killing the branch on a mispredict would drop a retirement. Acting on inputs during a stall, or repeating the redirect across a stalled cycle, would change the redirect count or the saved address.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

  localparam int unsigned NSTG    = 6;
  localparam int unsigned CAUSE_W = 3;

  localparam int unsigned ST_A = 0;
  localparam int unsigned ST_F = 1;
  localparam int unsigned ST_D = 2;
  localparam int unsigned ST_X = 3;
  localparam int unsigned ST_M = 4;
  localparam int unsigned ST_W = 5;

  typedef enum logic [CAUSE_W-1:0] {
    CS_NONE = 3'd0,
    CS_ITLB = 3'd1,
    CS_DTLB = 3'd2,
    CS_SYSC = 3'd3
  } cause_e;

endpackage

// File: rtl/pxc_slot.sv
module pxc_slot
  import pxc_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            d_valid_i,
  input  logic            d_kill_i,
  input  logic [PC_W-1:0] d_pc_i,
  input  cause_e          d_cause_i,
  output logic            q_valid_o,
  output logic            q_kill_o,
  output logic [PC_W-1:0] q_pc_o,
  output cause_e          q_cause_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_valid_o <= 1'b0;
      q_kill_o  <= 1'b0;
      q_pc_o    <= '0;
      q_cause_o <= CS_NONE;
    end else if (en_i) begin
      q_valid_o <= d_valid_i;
      q_kill_o  <= d_kill_i;
      q_pc_o    <= d_pc_i;
      q_cause_o <= d_cause_i;
    end
  end

endmodule

// File: rtl/pxc_tagger.sv
module pxc_tagger
  import pxc_pkg::*;
#(
  parameter int unsigned PC_W = 32,
  parameter cause_e      TAG  = CS_NONE
) (
  input  logic            src_valid_i,
  input  logic            src_kill_i,
  input  logic [PC_W-1:0] src_pc_i,
  input  cause_e          src_cause_i,
  input  logic            fault_i,
  input  logic            kill_i,
  output logic            dst_valid_o,
  output logic            dst_kill_o,
  output logic [PC_W-1:0] dst_pc_o,
  output cause_e          dst_cause_o
);

  logic tag_hit;

  always_comb begin
    tag_hit     = (TAG != CS_NONE) && src_valid_i && !src_kill_i &&
                  fault_i && (src_cause_i == CS_NONE);
    dst_valid_o = src_valid_i;
    dst_kill_o  = src_kill_i | kill_i;
    dst_pc_o    = src_pc_i;
    dst_cause_o = tag_hit ? TAG : src_cause_i;
  end

endmodule

// File: rtl/pxc_arb.sv
module pxc_arb
  import pxc_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned LIM_W = 3
) (
  input  logic             adv_i,
  input  logic             x_live_i,
  input  cause_e           x_cause_i,
  input  logic [PC_W-1:0]  x_pc_i,
  input  logic             m_live_i,
  input  logic [PC_W-1:0]  m_pc_i,
  input  logic             dtlb_i,
  input  logic             mispredict_i,
  output logic             exc_take_o,
  output logic [PC_W-1:0]  exc_pc_o,
  output cause_e           exc_cause_o,
  output logic [LIM_W-1:0] kill_lim_o,
  output logic             kill_new_o
);

  logic take_m, take_x, take_br;

  always_comb begin
    take_m  = adv_i && m_live_i && dtlb_i;
    take_x  = adv_i && x_live_i && (x_cause_i != CS_NONE) && !take_m;
    take_br = adv_i && x_live_i && (x_cause_i == CS_NONE) && mispredict_i && !take_m;

    exc_take_o  = take_m || take_x;
    exc_pc_o    = '0;
    exc_cause_o = CS_NONE;
    kill_lim_o  = '0;
    if (take_m) begin
      exc_pc_o    = m_pc_i;
      exc_cause_o = CS_DTLB;
      kill_lim_o  = LIM_W'(ST_W);
    end else if (take_x) begin
      exc_pc_o    = x_pc_i;
      exc_cause_o = x_cause_i;
      kill_lim_o  = LIM_W'(ST_M);
    end else if (take_br) begin
      kill_lim_o  = LIM_W'(ST_X);
    end
    kill_new_o = (kill_lim_o != '0);
  end

endmodule

// File: rtl/pxc_pipe_ctrl.sv
module pxc_pipe_ctrl
  import pxc_pkg::*;
#(
  parameter int unsigned     PC_W        = 32,
  parameter logic [PC_W-1:0] HANDLER_VEC = 32'h0000_0180
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stall_i,
  input  logic               in_valid_i,
  input  logic [PC_W-1:0]    in_pc_i,
  input  logic               itlb_miss_i,
  input  logic               syscall_i,
  input  logic               mispredict_i,
  input  logic               dtlb_miss_i,
  output logic               retire_valid_o,
  output logic [PC_W-1:0]    retire_pc_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic [PC_W-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o
);

  localparam int unsigned LIM_W = $clog2(NSTG + 1);

  logic                adv;
  logic [NSTG-1:0]     q_v, q_k, d_v, d_k, live;
  logic [PC_W-1:0]     q_pc [NSTG];
  logic [PC_W-1:0]     d_pc [NSTG];
  cause_e              q_cs [NSTG];
  cause_e              d_cs [NSTG];

  logic                exc_take;
  logic [PC_W-1:0]     exc_pc;
  cause_e              exc_cause;
  logic [LIM_W-1:0]    kill_lim;
  logic                kill_new;

  logic                redir_q, redir_d;
  logic [PC_W-1:0]     epc_q, epc_d;
  cause_e              cause_q, cause_d;
  logic                unused_ok;

  assign adv  = !stall_i;
  assign live = q_v & ~q_k;

  // entry into the address stage
  assign d_v[ST_A]  = in_valid_i;
  assign d_k[ST_A]  = kill_new;
  assign d_pc[ST_A] = in_pc_i;
  assign d_cs[ST_A] = CS_NONE;

  // stage-to-stage transfer with fault tagging and kill marking
  for (genvar s = 1; s < NSTG; s++) begin : g_xfer
    localparam cause_e TAG = (s == ST_D) ? CS_ITLB :
                             (s == ST_X) ? CS_SYSC : CS_NONE;
    logic fault_w;
    logic kill_w;
    if (s == ST_D) begin : g_itlb
      assign fault_w = itlb_miss_i;
    end else if (s == ST_X) begin : g_sysc
      assign fault_w = syscall_i;
    end else begin : g_none
      assign fault_w = 1'b0;
    end
    assign kill_w = (LIM_W'(s - 1) < kill_lim);

    pxc_tagger #(.PC_W(PC_W), .TAG(TAG)) u_tag (
      .src_valid_i (q_v[s-1]),
      .src_kill_i  (q_k[s-1]),
      .src_pc_i    (q_pc[s-1]),
      .src_cause_i (q_cs[s-1]),
      .fault_i     (fault_w),
      .kill_i      (kill_w),
      .dst_valid_o (d_v[s]),
      .dst_kill_o  (d_k[s]),
      .dst_pc_o    (d_pc[s]),
      .dst_cause_o (d_cs[s])
    );
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_slot
    pxc_slot #(.PC_W(PC_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (adv),
      .d_valid_i (d_v[s]),
      .d_kill_i  (d_k[s]),
      .d_pc_i    (d_pc[s]),
      .d_cause_i (d_cs[s]),
      .q_valid_o (q_v[s]),
      .q_kill_o  (q_k[s]),
      .q_pc_o    (q_pc[s]),
      .q_cause_o (q_cs[s])
    );
  end

  pxc_arb #(.PC_W(PC_W), .LIM_W(LIM_W)) u_arb (
    .adv_i        (adv),
    .x_live_i     (live[ST_X]),
    .x_cause_i    (q_cs[ST_X]),
    .x_pc_i       (q_pc[ST_X]),
    .m_live_i     (live[ST_M]),
    .m_pc_i       (q_pc[ST_M]),
    .dtlb_i       (dtlb_miss_i),
    .mispredict_i (mispredict_i),
    .exc_take_o   (exc_take),
    .exc_pc_o     (exc_pc),
    .exc_cause_o  (exc_cause),
    .kill_lim_o   (kill_lim),
    .kill_new_o   (kill_new)
  );

  // exception record, next state
  always_comb begin
    redir_d = exc_take;
    epc_d   = epc_q;
    cause_d = cause_q;
    if (exc_take) begin
      epc_d   = exc_pc;
      cause_d = exc_cause;
    end
  end

  // exception record, registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_q <= 1'b0;
      epc_q   <= '0;
      cause_q <= CS_NONE;
    end else begin
      redir_q <= redir_d;
      epc_q   <= epc_d;
      cause_q <= cause_d;
    end
  end

  assign unused_ok      = ^{q_cs[ST_W]};
  assign retire_valid_o = live[ST_W] && adv;
  assign retire_pc_o    = q_pc[ST_W];
  assign redirect_o     = redir_q;
  assign redirect_pc_o  = redir_q ? HANDLER_VEC : '0;
  assign epc_o          = epc_q;
  assign cause_o        = cause_q;

endmodule

// File: rtl/pxc_pipe_ctrl_chk.sv
module pxc_pipe_ctrl_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            stall_i,
  input logic            dtlb_i,
  input logic            retire_valid_i,
  input logic            redirect_i,
  input logic [PC_W-1:0] epc_i,
  input logic [2:0]      cause_i,
  input logic            m_live_i,
  input logic            x_live_i,
  input logic [2:0]      x_cause_i
);

  AST_STALL_NO_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !retire_valid_i);  // R3

  AST_STALL_NO_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !redirect_i);  // R3

  AST_STALL_KEEPS_EPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(epc_i) && $stable(cause_i)));  // R3

  AST_X_TAG_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && x_live_i && (x_cause_i != 3'd0) && !(dtlb_i && m_live_i))
      |=> (redirect_i && (cause_i == $past(x_cause_i))));  // R4

  AST_DTLB_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && dtlb_i && m_live_i) |=> (redirect_i && (cause_i == 3'd2)));  // R7

  AST_REDIRECT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> !redirect_i);  // R10

  AST_CAUSE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |-> ((cause_i != 3'd0) && (cause_i <= 3'd3)));  // R10

endmodule

bind pxc_pipe_ctrl pxc_pipe_ctrl_chk #(.PC_W(PC_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .stall_i        (stall_i),
  .dtlb_i         (dtlb_miss_i),
  .retire_valid_i (retire_valid_o),
  .redirect_i     (redirect_o),
  .epc_i          (epc_o),
  .cause_i        (cause_o),
  .m_live_i       (live[4]),
  .x_live_i       (live[3]),
  .x_cause_i      (q_cs[3])
);

// File: tb/tb_pxc_pipe_ctrl.sv
module tb_pxc_pipe_ctrl;

  localparam int          CLK_PERIOD = 10;
  localparam int          PC_W       = 32;
  localparam logic [31:0] HV         = 32'h0000_0180;
  localparam int          N          = 8;
  localparam int          EP_CYC     = 64;

  logic            clk, rst_n, stall, in_valid, itlb, sysc, mis, dtlb;
  logic [PC_W-1:0] in_pc;
  logic            retire_valid, redirect;
  logic [PC_W-1:0] retire_pc, redirect_pc, epc;
  logic [2:0]      cause;

  pxc_pipe_ctrl #(.PC_W(PC_W), .HANDLER_VEC(HV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .in_valid_i(in_valid),
    .in_pc_i(in_pc), .itlb_miss_i(itlb), .syscall_i(sysc), .mispredict_i(mis),
    .dtlb_miss_i(dtlb), .retire_valid_o(retire_valid), .retire_pc_o(retire_pc),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc), .epc_o(epc), .cause_o(cause)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit a_itlb[N], a_dtlb[N], a_sys[N], a_br[N], sq[N];
  int sh[6];
  logic [31:0] base;
  int ep_no = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  function automatic logic [31:0] pc_of(int i);
    return base + 32'(4 * i);
  endfunction

  function automatic bit has_fault(int i);
    return a_itlb[i] || a_dtlb[i] || a_sys[i];
  endfunction

  function automatic int first_fault();
    for (int i = 0; i < N; i++) if (!sq[i] && has_fault(i)) return i;
    return N;
  endfunction

  function automatic logic [2:0] cause_of(int i);
    if (a_itlb[i]) return 3'd1;
    if (a_sys[i])  return 3'd3;
    return 3'd2;
  endfunction

  function automatic bit br_live(int b);
    if (sq[b]) return 1'b0;
    for (int j = 0; j < b; j++) if (!sq[j] && has_fault(j)) return 1'b0;
    return !(a_itlb[b] || a_sys[b]);
  endfunction

  function automatic int next_live(int p);
    int e = p;
    while (e < N && sq[e]) e++;
    return e;
  endfunction

  function automatic bit attr(int idx, int kind);
    if (idx < 0) return 1'b0;
    case (kind)
      0: return a_itlb[idx];
      1: return a_sys[idx];
      2: return a_br[idx];
      default: return a_dtlb[idx];
    endcase
  endfunction

  function automatic string req_of(logic [2:0] c, string tag);
    if (tag != "") return tag;
    if (c == 3'd1) return "R4";
    if (c == 3'd3) return "R5";
    return "R6";
  endfunction

  task automatic clear_attrs();
    for (int i = 0; i < N; i++) begin
      a_itlb[i] = 0; a_dtlb[i] = 0; a_sys[i] = 0; a_br[i] = 0; sq[i] = 0;
    end
  endtask

  task automatic run_episode(input int smode, input int bmode, input string tag);
    int ptr = 0, nxt = 0, redir_cnt = 0, f, e;
    bit stop = 0, stl, iss, mis_d;
    ep_no++;
    base = 32'h0001_0000 + 32'(ep_no * 'h100);
    for (int s = 0; s < 6; s++) sh[s] = -1;
    for (int c = 0; c < EP_CYC; c++) begin
      @(negedge clk);
      if (redirect) begin
        redir_cnt++;
        stop = 1;
        f = first_fault();
        check(f < N, "R8", "redirect with no live fault", 32'(f), 32'(N));
        if (f < N) begin
          check(epc == pc_of(f), req_of(cause_of(f), tag), "epc", epc, pc_of(f));
          check(cause == cause_of(f), req_of(cause_of(f), tag), "cause", 32'(cause), 32'(cause_of(f)));
        end
        check(redirect_pc == HV, "R10", "handler vector", redirect_pc, HV);
      end
      case (smode)
        1: stl = (c % 3 == 1);
        2: stl = (c % 5 == 2) || (c % 5 == 3);
        default: stl = 1'b0;
      endcase
      iss = !stop && (nxt < N) && !(bmode == 1 && (c % 4 == 3));
      in_valid = iss;
      in_pc    = iss ? pc_of(nxt) : 32'h0;
      stall    = stl;
      mis_d    = attr(sh[3], 2);
      if (stl) begin
        itlb = 1; sysc = 1; mis = 1; dtlb = 1;
      end else begin
        itlb = attr(sh[1], 0);
        sysc = attr(sh[2], 1);
        mis  = mis_d;
        dtlb = attr(sh[4], 3);
      end
      #(CLK_PERIOD/4);
      if (stl) check(!retire_valid, "R3", "retire while stalled", 32'(retire_valid), 32'h0);
      if (retire_valid) begin
        e = next_live(ptr);
        check(e < N && !has_fault(e), "R2", "retire of a faulting or absent instruction",
              retire_pc, (e < N) ? pc_of(e) : 32'hffff_ffff);
        check(e < N && retire_pc == pc_of(e), "R2", "retire order", retire_pc,
              (e < N) ? pc_of(e) : 32'hffff_ffff);
        ptr = e + 1;
      end
      if (!stl) begin
        if (mis_d && br_live(sh[3])) begin
          for (int s = 0; s < 3; s++) if (sh[s] >= 0) sq[sh[s]] = 1;
          if (iss) sq[nxt] = 1;
        end
        for (int s = 5; s > 0; s--) sh[s] = sh[s-1];
        sh[0] = iss ? nxt : -1;
        if (iss) nxt++;
      end
    end
    f = first_fault();
    e = next_live(ptr);
    check(e == f, (f < N) ? "R8" : "R9", "retired count ends at first fault", 32'(e), 32'(f));
    check(redir_cnt == ((f < N) ? 1 : 0), "R10", "redirect pulses", 32'(redir_cnt),
          32'((f < N) ? 1 : 0));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
    $finish;
  end

  initial begin
    rst_n = 0; stall = 0; in_valid = 0; in_pc = '0;
    itlb = 0; sysc = 0; mis = 0; dtlb = 0;
    clear_attrs();
    repeat (3) @(negedge clk);
    check(!redirect && !retire_valid, "R1", "control in reset", {30'h0, redirect, retire_valid}, 32'h0);
    check(epc == 0 && cause == 0, "R1", "record in reset", epc | 32'(cause), 32'h0);
    rst_n = 1;
    @(negedge clk);
    check(!redirect && !retire_valid && epc == 0 && cause == 0, "R1", "after release",
          epc | 32'(cause) | 32'(redirect), 32'h0);

    for (int sm = 0; sm < 3; sm++) begin
      for (int bm = 0; bm < 2; bm++) begin
        clear_attrs();
        run_episode(sm, bm, "R2");
        for (int k = 0; k < 3; k++) begin
          for (int p = 0; p < N; p++) begin
            clear_attrs();
            if (k == 0) a_itlb[p] = 1;
            else if (k == 1) a_sys[p] = 1;
            else a_dtlb[p] = 1;
            run_episode(sm, bm, "");
          end
        end
        clear_attrs();
        a_itlb[3] = 1; a_sys[3] = 1;
        run_episode(sm, bm, "R5");
        for (int i = 0; i < N - 1; i++) begin
          clear_attrs();
          a_dtlb[i] = 1; a_itlb[i+1] = 1;
          run_episode(sm, bm, "R7");
        end
        for (int b = 0; b < 3; b += 2) begin
          for (int k = 1; k <= 5; k++) begin
            clear_attrs();
            a_br[b] = 1;
            if (b + k < N) a_itlb[b+k] = 1;
            if (k == 2) a_dtlb[b] = 1;
            run_episode(sm, bm, "R9");
          end
        end
      end
    end
    report();
    $finish;
  end

endmodule